// File: doc/BRIEF.md
# Windowed Key-Serviced Watchdog

This block is a supervision timer for a processor subsystem. Once enabled it counts down from a programmed period. Software has to service it before the count expires, and it does so by writing a two-byte key to a dedicated service port. A service is honoured only when the remaining count has fallen into a programmed window near the end of the period. A service that completes too early, or a key write that breaks the sequence, is a fault and requests a reset at once.

In staged mode the first expiry raises an interrupt and restarts the period. Software can still rescue the system with a valid service during that second period. If the second period also expires, the block requests a reset. In direct mode the first expiry requests the reset. Every reset request is a pulse of fixed length. The count advances only on cycles where the external count-enable is high, so clock selection and prescaling stay outside the block. A control bit decides whether the count continues or freezes while the chip is in its pseudo-stop low-power state. Each configuration register (period, window, control) accepts one write after reset and then ignores later writes.

Top module: `kwd_watchdog`

## Requirements
- R1: While enabled, the counter is loaded with the period P and decrements on each cycle where cnt_en is high. Expiry happens on the (P+1)-th counted cycle after enabling. Cycles with cnt_en low do not count.
- R2: In staged mode (control bit 1 = 1), the first expiry sets irq and restarts the period. A second consecutive expiry clears irq and starts a reset request.
- R3: In direct mode (control bit 1 = 0), an expiry starts a reset request and irq never rises.
- R4: A service is the byte 0x55 followed by the byte 0xAA on the service port; idle cycles between the two bytes are allowed. Any other byte, 0xAA with no preceding 0x55, or 0x55 twice in a row starts a reset request on the same edge.
- R5: The 0xAA write completes a service only if the count value just before that edge is at most the window register. Otherwise it starts a reset request. A completion on the edge where the count expires is a valid service.
- R6: A valid service reloads the counter with the period and clears a pending irq.
- R7: rst_req stays high for exactly 16 cycles. During the pulse the counter is held at the period and service writes are ignored, including a 0x55 first byte. Counting restarts after the pulse.
- R8: With lp_mode high and control bit 2 = 0 the count freezes; with control bit 2 = 1 it keeps counting.
- R9: Registers are selected by cfg_addr: 0 = period, 1 = window, 2 = control (bit 0 enable, bit 1 staged, bit 2 run in low power). Each register accepts only its first write after reset.
- R10: With control bit 0 = 0 the block never counts, never raises irq or rst_req, and ignores service writes.
- R11: After reset irq and rst_req are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration register select |
| cfg_wdata | input | CNT_W | Configuration write data |
| svc_we | input | 1 | Service key write strobe |
| svc_data | input | 8 | Service key byte |
| cnt_en | input | 1 | Count-enable tick from the external clock selector |
| lp_mode | input | 1 | Chip is in the pseudo-stop low-power state |
| irq | output | 1 | First-stage expiry interrupt |
| rst_req | output | 1 | Reset request pulse |

## Verification
The hardest case to reach from the ports is a service that completes on the very edge where the counter reaches zero. This is where the window test, the reload and the expiry all compete. It is also hard to show that a key byte written during the reset pulse is really discarded. The bench keeps cnt_en high and counts edges from the enabling control write, so the count value in front of every service edge is known exactly. It then sweeps the position of the service across the whole period for several period and window pairs, the last position included. To show that a key byte is discarded during the pulse, the bench writes 0x55 inside the pulse and 0xAA after it. The 0xAA must then be taken as a broken sequence.

// File: rtl/kwd_pkg.sv
package kwd_pkg;

    localparam int KEY_W = 8;
    localparam logic [KEY_W-1:0] KEY_OPEN  = 8'h55;
    localparam logic [KEY_W-1:0] KEY_CLOSE = 8'hAA;

    typedef enum logic [1:0] {
        SEL_PERIOD = 2'd0,
        SEL_WINDOW = 2'd1,
        SEL_CTRL   = 2'd2
    } reg_sel_e;

    typedef struct packed {
        logic lp_run;
        logic staged;
        logic en;
    } ctrl_t;

    typedef enum logic {
        KS_IDLE  = 1'b0,
        KS_ARMED = 1'b1
    } key_state_e;

    typedef enum logic [1:0] {
        EV_NONE = 2'd0,
        EV_GOOD = 2'd1,
        EV_BAD  = 2'd2
    } svc_ev_e;

    typedef struct packed {
        key_state_e nxt;
        svc_ev_e    ev;
    } key_step_t;

    function automatic key_step_t key_step(key_state_e st, logic [KEY_W-1:0] d, logic in_win);
        key_step_t r;
        r.nxt = KS_IDLE;
        r.ev  = EV_BAD;
        if (st == KS_IDLE && d == KEY_OPEN) begin
            r.nxt = KS_ARMED;
            r.ev  = EV_NONE;
        end else if (st == KS_ARMED && d == KEY_CLOSE) begin
            r.ev = in_win ? EV_GOOD : EV_BAD;
        end
        return r;
    endfunction

endpackage

// File: rtl/kwd_cfg_regs.sv
module kwd_cfg_regs
    import kwd_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter logic [CNT_W-1:0] DEF_PERIOD = 1000,
    parameter logic [CNT_W-1:0] DEF_WINDOW = 1000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [1:0]       addr,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] window,
    output ctrl_t            ctrl
);
    localparam int NREG = 3;

    logic [NREG-1:0] locked;
    logic [NREG-1:0] hit;

    for (genvar i = 0; i < NREG; i++) begin : g_hit
        assign hit[i] = we && (addr == 2'(i)) && !locked[i];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            locked <= '0;
            period <= DEF_PERIOD;
            window <= DEF_WINDOW;
            ctrl   <= '0;
        end else begin
            locked <= locked | hit;
            if (hit[SEL_PERIOD]) period <= wdata;
            if (hit[SEL_WINDOW]) window <= wdata;
            if (hit[SEL_CTRL])   ctrl   <= ctrl_t'(wdata[2:0]);
        end
    end

endmodule

// File: rtl/kwd_key_seq.sv
module kwd_key_seq
    import kwd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             active,
    input  logic             we,
    input  logic [KEY_W-1:0] data,
    input  logic             in_win,
    output svc_ev_e          ev
);
    key_state_e st;
    key_step_t  step;

    always_comb begin
        step = key_step(st, data, in_win);
        ev   = (active && we) ? step.ev : EV_NONE;
    end

    always_ff @(posedge clk) begin
        if (rst || !active) st <= KS_IDLE;
        else if (we)        st <= step.nxt;
    end

endmodule

// File: rtl/kwd_timer.sv
module kwd_timer
    import kwd_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int RST_CYC = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  ctrl_t            ctrl,
    input  logic [CNT_W-1:0] period,
    input  logic [CNT_W-1:0] window,
    input  logic             tick,
    input  logic             lp_mode,
    input  svc_ev_e          ev,
    output logic [CNT_W-1:0] cnt,
    output logic             in_win,
    output logic             busy,
    output logic             irq
);
    localparam int RC_W = $clog2(RST_CYC + 1);

    logic [RC_W-1:0] rc;
    logic            run;

    assign run    = tick && (!lp_mode || ctrl.lp_run);
    assign busy   = (rc != '0);
    assign in_win = (cnt <= window);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            rc  <= '0;
            irq <= 1'b0;
        end else begin
            if (busy) rc <= rc - 1'b1;
            if (!ctrl.en) begin
                cnt <= period;
                irq <= 1'b0;
            end else if (busy) begin
                cnt <= period;
            end else if (ev == EV_BAD) begin
                rc  <= RC_W'(RST_CYC);
                cnt <= period;
                irq <= 1'b0;
            end else if (ev == EV_GOOD) begin
                cnt <= period;
                irq <= 1'b0;
            end else if (run) begin
                if (cnt == '0) begin
                    cnt <= period;
                    if (ctrl.staged && !irq) begin
                        irq <= 1'b1;
                    end else begin
                        irq <= 1'b0;
                        rc  <= RC_W'(RST_CYC);
                    end
                end else begin
                    cnt <= cnt - 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/kwd_watchdog.sv
module kwd_watchdog
    import kwd_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int RST_CYC = 16,
    parameter logic [CNT_W-1:0] DEF_PERIOD = 1000,
    parameter logic [CNT_W-1:0] DEF_WINDOW = 1000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_addr,
    input  logic [CNT_W-1:0] cfg_wdata,
    input  logic             svc_we,
    input  logic [7:0]       svc_data,
    input  logic             cnt_en,
    input  logic             lp_mode,
    output logic             irq,
    output logic             rst_req
);
    logic [CNT_W-1:0] period_q;
    logic [CNT_W-1:0] window_q;
    ctrl_t            ctrl_q;
    logic [CNT_W-1:0] cnt_q;
    logic             in_win;
    logic             busy;
    svc_ev_e          svc_ev;

    kwd_cfg_regs #(
        .CNT_W(CNT_W), .DEF_PERIOD(DEF_PERIOD), .DEF_WINDOW(DEF_WINDOW)
    ) u_cfg (
        .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
        .period(period_q), .window(window_q), .ctrl(ctrl_q)
    );

    kwd_key_seq u_key (
        .clk(clk), .rst(rst), .active(ctrl_q.en && !busy), .we(svc_we),
        .data(svc_data), .in_win(in_win), .ev(svc_ev)
    );

    kwd_timer #(.CNT_W(CNT_W), .RST_CYC(RST_CYC)) u_tmr (
        .clk(clk), .rst(rst), .ctrl(ctrl_q), .period(period_q), .window(window_q),
        .tick(cnt_en), .lp_mode(lp_mode), .ev(svc_ev), .cnt(cnt_q),
        .in_win(in_win), .busy(busy), .irq(irq)
    );

    assign rst_req = busy;

endmodule

// File: rtl/kwd_checker.sv
module kwd_checker
    import kwd_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int RST_CYC = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             cfg_we,
    input logic [1:0]       cfg_addr,
    input logic             lp_mode,
    input logic             irq,
    input logic             rst_req,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] period,
    input ctrl_t            ctrl,
    input svc_ev_e          ev
);
    localparam int HW = $clog2(RST_CYC + 2);

    logic [HW-1:0] hi_len;
    logic          period_written;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_len         <= '0;
            period_written <= 1'b0;
        end else begin
            hi_len <= rst_req ? hi_len + 1'b1 : '0;
            if (cfg_we && cfg_addr == 2'd0) period_written <= 1'b1;
        end
    end

    p_pulse_len_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(rst_req) |-> hi_len == HW'(RST_CYC));

    p_irq_staged_only_r3: assert property (@(posedge clk) disable iff (rst)
        irq |-> ctrl.staged);

    p_good_clears_irq_r6: assert property (@(posedge clk) disable iff (rst)
        (ev == EV_GOOD) |=> !irq);

    p_bad_resets_r4: assert property (@(posedge clk) disable iff (rst)
        (ev == EV_BAD) |=> rst_req);

    p_lp_freeze_r8: assert property (@(posedge clk) disable iff (rst)
        (ctrl.en && !rst_req && lp_mode && !ctrl.lp_run && ev == EV_NONE) |=> $stable(cnt));

    p_period_lock_r9: assert property (@(posedge clk) disable iff (rst)
        (period_written && cfg_we && cfg_addr == 2'd0) |=> $stable(period));

    p_disabled_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        !ctrl.en |-> (!irq && !rst_req));

    p_pulse_clears_irq_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(rst_req) |-> !irq);

endmodule

bind kwd_watchdog kwd_checker #(.CNT_W(CNT_W), .RST_CYC(RST_CYC)) u_kwd_checker (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .lp_mode(lp_mode),
    .irq(irq), .rst_req(rst_req), .cnt(cnt_q), .period(period_q), .ctrl(ctrl_q),
    .ev(svc_ev)
);

// File: tb/test_kwd_watchdog.sv
module test_kwd_watchdog;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_we;
    logic [1:0]  cfg_addr;
    logic [15:0] cfg_wdata;
    logic        svc_we;
    logic [7:0]  svc_data;
    logic        cnt_en;
    logic        lp_mode;
    logic        irq;
    logic        rst_req;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    kwd_watchdog i_kwd_watchdog (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .svc_we(svc_we), .svc_data(svc_data), .cnt_en(cnt_en), .lp_mode(lp_mode),
        .irq(irq), .rst_req(rst_req)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
        svc_we = 1'b0; svc_data = '0; cnt_en = 1'b1; lp_mode = 1'b0;
        idle(3);
        rst = 1'b0;
    endtask

    task automatic cfg_wr(input logic [1:0] a, input logic [15:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic key(input logic [7:0] d);
        svc_we = 1'b1; svc_data = d;
        @(negedge clk);
        svc_we = 1'b0;
    endtask

    // Leaves the bench at the negedge right after the enabling write (j = 0, count = P).
    task automatic setup(input int p, input int w, input logic [2:0] c);
        do_reset();
        cfg_wr(2'd0, 16'(p));
        cfg_wr(2'd1, 16'(w));
        cfg_wr(2'd2, {13'b0, c});
    endtask

    task automatic pulse_len(input string req, input int exp_len);
        int len = 0;
        while (rst_req && len < 40) begin
            len++;
            idle(1);
        end
        checks++;
        if (len != exp_len) begin
            errors++;
            $display("FAIL %s pulse length: actual %0d expected %0d", req, len, exp_len);
        end
    endtask

    task automatic run_all();
        // R11 reset state
        do_reset();
        chk("R11", "irq after reset", irq, 1'b0);
        chk("R11", "rst_req after reset", rst_req, 1'b0);

        // R2 staged escalation, R7 pulse length
        setup(5, 5, 3'b011);
        idle(5);  chk("R1", "no expiry at j=P", irq, 1'b0);
        idle(1);  chk("R2", "irq at first expiry", irq, 1'b1);
        chk("R2", "no reset at first expiry", rst_req, 1'b0);
        idle(5);  chk("R2", "irq held", irq, 1'b1);
        idle(1);  chk("R2", "reset at second expiry", rst_req, 1'b1);
        chk("R2", "irq cleared by escalation", irq, 1'b0);
        pulse_len("R7", 16);

        // R3 direct mode, R7 hold and restart, key ignored during pulse
        setup(5, 5, 3'b001);
        idle(5);  chk("R3", "no reset before expiry", rst_req, 1'b0);
        idle(1);  chk("R3", "reset at expiry", rst_req, 1'b1);
        chk("R3", "no irq in direct mode", irq, 1'b0);
        pulse_len("R7", 16);           // now at j = P+17
        idle(5);  chk("R7", "restart from period, j=2P+17", rst_req, 1'b0);
        idle(1);  chk("R7", "second expiry j=2P+18", rst_req, 1'b1);

        setup(5, 5, 3'b001);
        idle(6);                       // pulse starts at j=6
        idle(3);  key(8'h55);          // first byte inside the pulse
        while (rst_req) idle(1);
        key(8'hAA);
        chk("R7", "first byte during pulse discarded", rst_req, 1'b1);

        // R5/R4/R6 sweep over service position
        for (int cfg = 0; cfg < 3; cfg++) begin
            int p = (cfg == 2) ? 6 : 4;
            int w = (cfg == 0) ? 1 : ((cfg == 1) ? 4 : 3);
            for (int k = 0; k < p; k++) begin
                logic inwin;
                inwin = ((p - k - 1) <= w);
                setup(p, w, 3'b011);
                idle(k);
                key(8'h55);
                key(8'hAA);
                if (inwin) begin
                    chk("R5", "in-window service accepted", rst_req, 1'b0);
                    idle(p);  chk("R6", "reloaded, no early expiry", irq, 1'b0);
                    idle(1);  chk("R6", "expiry one period after service", irq, 1'b1);
                end else begin
                    chk("R5", "early service faults", rst_req, 1'b1);
                end
            end
        end

        // R6 service clears pending irq
        setup(4, 4, 3'b011);
        idle(5);  chk("R2", "irq pending", irq, 1'b1);
        key(8'h55); key(8'hAA);
        chk("R6", "irq cleared by service", irq, 1'b0);
        idle(4);  chk("R6", "no reset after rescue", rst_req, 1'b0);
        chk("R6", "irq stays low", irq, 1'b0);
        idle(1);  chk("R6", "new first-stage irq", irq, 1'b1);

        // R4 broken sequences
        setup(8, 8, 3'b011); idle(2); key(8'h12);
        chk("R4", "wrong byte faults", rst_req, 1'b1);
        setup(8, 8, 3'b011); key(8'hAA);
        chk("R4", "close without open faults", rst_req, 1'b1);
        setup(8, 8, 3'b011); key(8'h55); key(8'h55);
        chk("R4", "open twice faults", rst_req, 1'b1);
        setup(8, 8, 3'b011); key(8'h55); key(8'h3C);
        chk("R4", "wrong second byte faults", rst_req, 1'b1);
        setup(8, 8, 3'b011); key(8'h55); idle(2); key(8'hAA);
        chk("R4", "gap between bytes allowed", rst_req, 1'b0);

        // R9 write-once
        setup(5, 5, 3'b001);
        cfg_wr(2'd0, 16'd20); cfg_wr(2'd2, 16'd0); cfg_wr(2'd1, 16'd0);
        idle(2);  chk("R9", "locked period, j=5", rst_req, 1'b0);
        idle(1);  chk("R9", "locked period and ctrl, j=6", rst_req, 1'b1);
        setup(6, 6, 3'b011);
        cfg_wr(2'd1, 16'd0); key(8'h55); key(8'hAA);
        chk("R9", "locked window still open", rst_req, 1'b0);

        // R8 low power
        setup(6, 6, 3'b001);
        lp_mode = 1'b1; idle(10);
        chk("R8", "frozen in low power", rst_req, 1'b0);
        lp_mode = 1'b0; idle(6);
        chk("R8", "resumed, j=16", rst_req, 1'b0);
        idle(1);  chk("R8", "expiry delayed to j=17", rst_req, 1'b1);
        setup(6, 6, 3'b101);
        lp_mode = 1'b1; idle(6);
        chk("R8", "running in low power, j=6", rst_req, 1'b0);
        idle(1);  chk("R8", "expiry at j=7 in low power", rst_req, 1'b1);
        lp_mode = 1'b0;

        // R1 count enable gating
        setup(5, 5, 3'b001);
        cnt_en = 1'b0; idle(4); cnt_en = 1'b1;
        idle(5);  chk("R1", "paused ticks, j=9", rst_req, 1'b0);
        idle(1);  chk("R1", "expiry at j=10", rst_req, 1'b1);

        // R10 disabled
        setup(3, 3, 3'b010);
        idle(20);
        chk("R10", "no irq when disabled", irq, 1'b0);
        chk("R10", "no reset when disabled", rst_req, 1'b0);
        key(8'h12);
        chk("R10", "key ignored when disabled", rst_req, 1'b0);
        cfg_wr(2'd2, 16'd3); idle(10);
        chk("R10", "enable after lock ignored", irq, 1'b0);
        chk("R10", "still no reset", rst_req, 1'b0);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule